// File: doc/BRIEF.md
# Tree-Structured Interrupt Aggregator

This block gathers a large set of interrupt source lines into one summary interrupt. Its status sits in a three-level tree: single sources, blocks of eight sources, and masters of up to eight blocks. Software reaches the status and configuration through a small synchronous 8-bit register port. The root register shows which masters hold activity. Each master status register shows which of its blocks hold activity. A block-select pointer then opens the pending and real-time status bytes of one block, so software can walk from the summary output down to the source that fired.

Every source has its own trigger setup: edge or level mode, plus separate enables for the rising/high direction and the falling/low direction. Software writes this setup indirectly. It first loads the block-select pointer, then writes one packed configuration byte. That byte names the source within the block, carries a write-enable bit, and can clear the source's pending flag in the same access.

Each source line passes through a two-flop synchroniser before any detection. The summary output is high while any source has its pending flag set.

Top module: `irq_tree_top`

## Requirements
- R1: The register window starts at address 0x1BB. The offsets are: +0 root, +1..+4 master status for masters 0..3, +5 block-select pointer (read/write, low 5 bits), +6 pending byte of the selected block, +7 configuration byte (write-only, reads as zero), +8 real-time byte of the selected block. Writes to any other address are ignored, and reads from any other address return zero.
- R2: After reset every pending flag is clear, every source is in edge mode with both directions masked, the block-select pointer is 0, and the summary output is low.
- R3: Each source is synchronised through two flops. At offset +8, bit i shows the synchronised level of source sel*8+i.
- R4: A configuration byte takes effect only when bit 7 is 1. Bits 6:4 pick the source within the selected block. Bit 3 clears its pending flag. Bit 2 masks the rising/high direction. Bit 1 masks the falling/low direction. Bit 0 = 1 selects level mode. A byte with bit 7 = 0 changes nothing.
- R5: In edge mode with bit 2 = 0, a synchronised rising edge sets the pending flag. The flag then holds, through later input changes, until it is cleared.
- R6: In edge mode with bit 1 = 0, a falling edge sets the pending flag. With bits 2 and 1 both 0, both edges set it.
- R7: In level mode, bit 2 = 0 means active-high and bit 1 = 0 means active-low. The pending flag is set while the line is active. A clear issued while the line is still active leaves the flag set.
- R8: A source with both direction masks set never sets its pending flag.
- R9: At offset +6, bit i shows the pending flag of source sel*8+i. In master register m, bit i is set when block m*8+i has any pending source. Root bit m+1 is set when master m has any active block, and root bit 0 always reads 0.
- R10: The summary output is high exactly when the root register is non-zero.
- R11: The clear bit acts once and is not stored. A later enabled configuration write with bit 3 = 0 leaves a set pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 256 | Asynchronous interrupt source lines |
| regAddr | input | 10 | Register address |
| regWe | input | 1 | Write strobe, sampled on the clock edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| irqOut | output | 1 | Summary interrupt |

## Verification
The assertions check four properties on every cycle: a fully masked source never raises its flag, an edge-mode flag never drops without a clear, configuration storage stays unchanged when no enabled configuration write occurs, and a write outside the decoded offsets leaves the block pointer unchanged. A further assertion ties the summary output to a non-zero root register. Only the directed scenarios can show the detection rules themselves. These include the trigger direction in edge and level mode, the re-assertion of a level flag after a clear, the one-shot nature of the clear bit, and the bit positions at which each source appears in the block, master and root bytes.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int SRC_PER_BLK = 8;
  localparam int IDX_W = 3;

  localparam int OFF_ROOT = 0;
  localparam int OFF_MST0 = 1;
  localparam int OFF_SEL  = 5;
  localparam int OFF_PEND = 6;
  localparam int OFF_CFG  = 7;
  localparam int OFF_RT   = 8;
  localparam int MAX_MASTERS = 4;

  typedef struct packed {
    logic             cfgWrite;
    logic [IDX_W-1:0] idx;
    logic             clr;
    logic             mskRe;
    logic             mskFe;
    logic             lvl;
  } cfgStrobe_t;
endpackage

// File: rtl/irq_tree_dp.sv
module irq_tree_dp
  import irq_tree_pkg::*;
#(
  parameter int NUM_BLOCKS = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_BLOCKS*SRC_PER_BLK-1:0]  srcIn,
  input  cfgStrobe_t                         strb,
  input  logic [$clog2(NUM_BLOCKS)-1:0]      blkSel,
  output logic [NUM_BLOCKS-1:0]              blkAny,
  output logic [SRC_PER_BLK-1:0]             selPend,
  output logic [SRC_PER_BLK-1:0]             selRt,
  output logic                               anyPend
);
  localparam int NSRC  = NUM_BLOCKS * SRC_PER_BLK;
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic [NSRC-1:0] syncA, syncB, prevLvl, pending;
  logic [NSRC-1:0] lvlMode, mskRe, mskFe;
  logic [NSRC-1:0] hitVec, clrVec, setVec, riseVec, fallVec, edgeSet, lvlSet;

  always_comb begin
    hitVec = '0;
    if (strb.cfgWrite) hitVec[{blkSel, strb.idx}] = 1'b1;
    clrVec  = hitVec & {NSRC{strb.clr}};
    riseVec = syncB & ~prevLvl;
    fallVec = ~syncB & prevLvl;
    edgeSet = (riseVec & ~mskRe) | (fallVec & ~mskFe);
    lvlSet  = (syncB & ~mskRe) | (~syncB & ~mskFe);
    setVec  = (lvlMode & lvlSet) | (~lvlMode & edgeSet);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
      pending <= '0;
      lvlMode <= '0;
      mskRe   <= '1;
      mskFe   <= '1;
    end else begin
      syncA   <= srcIn;
      syncB   <= syncA;
      prevLvl <= syncB;
      pending <= (pending & ~clrVec) | setVec;
      lvlMode <= (lvlMode & ~hitVec) | (hitVec & {NSRC{strb.lvl}});
      mskRe   <= (mskRe & ~hitVec) | (hitVec & {NSRC{strb.mskRe}});
      mskFe   <= (mskFe & ~hitVec) | (hitVec & {NSRC{strb.mskFe}});
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blkAny[b] = |pending[b*SRC_PER_BLK +: SRC_PER_BLK];
  end

  assign selPend = pending[{blkSel, {IDX_W{1'b0}}} +: SRC_PER_BLK];
  assign selRt   = syncB[{blkSel, {IDX_W{1'b0}}} +: SRC_PER_BLK];
  assign anyPend = |pending;

  // R8: a fully masked source never gains a pending flag
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & $past(mskRe & mskFe)) == '0));

  // R5: edge-mode flags only drop through a clear
  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pending & ~lvlMode & ~clrVec) & ~pending) == '0));

  // R4: configuration storage only moves on an enabled write
  assert_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgWrite |=> ($stable(lvlMode) && $stable(mskRe) && $stable(mskFe)));

  logic unusedBlk;
  assign unusedBlk = ^BLK_W;
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int                NUM_BLOCKS     = 32,
  parameter int                BLK_PER_MASTER = 8,
  parameter int                ADDR_W         = 10,
  parameter logic [ADDR_W-1:0] BASE           = 10'h1BB
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWe,
  input  logic [7:0]                    regWdata,
  input  logic [NUM_BLOCKS-1:0]         blkAny,
  input  logic [SRC_PER_BLK-1:0]        selPend,
  input  logic [SRC_PER_BLK-1:0]        selRt,
  output logic [$clog2(NUM_BLOCKS)-1:0] blkSel,
  output cfgStrobe_t                    strb,
  output logic [7:0]                    regRdata,
  output logic [7:0]                    rootByte
);
  localparam int BLK_W       = $clog2(NUM_BLOCKS);
  localparam int NUM_MASTERS = NUM_BLOCKS / BLK_PER_MASTER;

  logic [ADDR_W-1:0] offs;
  logic              inWin;
  logic [7:0]        mstByte [NUM_MASTERS];

  assign offs  = regAddr - BASE;
  assign inWin = (regAddr >= BASE) && (offs <= ADDR_W'(OFF_RT));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign mstByte[m] = 8'(blkAny[m*BLK_PER_MASTER +: BLK_PER_MASTER]);
  end

  always_comb begin
    rootByte = '0;
    for (int m = 0; m < NUM_MASTERS; m++) rootByte[m+1] = |mstByte[m];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blkSel <= '0;
    else if (regWe && inWin && offs == ADDR_W'(OFF_SEL)) blkSel <= regWdata[BLK_W-1:0];
  end

  always_comb begin
    strb.cfgWrite = regWe && inWin && (offs == ADDR_W'(OFF_CFG)) && regWdata[7];
    strb.idx      = regWdata[6:4];
    strb.clr      = regWdata[3];
    strb.mskRe    = regWdata[2];
    strb.mskFe    = regWdata[1];
    strb.lvl      = regWdata[0];
  end

  always_comb begin
    regRdata = '0;
    if (inWin) begin
      if (offs == ADDR_W'(OFF_ROOT)) regRdata = rootByte;
      for (int m = 0; m < NUM_MASTERS; m++)
        if (offs == ADDR_W'(OFF_MST0 + m)) regRdata = mstByte[m];
      if (offs == ADDR_W'(OFF_SEL))  regRdata = 8'(blkSel);
      if (offs == ADDR_W'(OFF_PEND)) regRdata = selPend;
      if (offs == ADDR_W'(OFF_RT))   regRdata = selRt;
    end
  end

  // R1: writes outside the pointer offset leave the pointer alone
  assert_ptr_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !(inWin && offs == ADDR_W'(OFF_SEL))) |=> $stable(blkSel));
endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_tree_pkg::*;
#(
  parameter int                NUM_BLOCKS     = 32,
  parameter int                BLK_PER_MASTER = 8,
  parameter int                ADDR_W         = 10,
  parameter logic [ADDR_W-1:0] BASE           = 10'h1BB
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_BLOCKS*SRC_PER_BLK-1:0] srcIn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic                              regWe,
  input  logic [7:0]                        regWdata,
  output logic [7:0]                        regRdata,
  output logic                              irqOut
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  cfgStrobe_t              strb;
  logic [BLK_W-1:0]        blkSel;
  logic [NUM_BLOCKS-1:0]   blkAny;
  logic [SRC_PER_BLK-1:0]  selPend, selRt;
  logic [7:0]              rootByte;

  irq_tree_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_PER_MASTER(BLK_PER_MASTER),
    .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .blkAny(blkAny), .selPend(selPend), .selRt(selRt),
    .blkSel(blkSel), .strb(strb), .regRdata(regRdata), .rootByte(rootByte)
  );

  irq_tree_dp #(.NUM_BLOCKS(NUM_BLOCKS)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb), .blkSel(blkSel),
    .blkAny(blkAny), .selPend(selPend), .selRt(selRt), .anyPend(irqOut)
  );

  // R10: summary output agrees with the root register
  assert_irq_root_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (rootByte != 8'h00));
endmodule

// File: tb/sim_irq_tree_top.sv
module sim_irq_tree_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] srcIn = '0;
  logic [9:0]   regAddr = '0;
  logic         regWe = 1'b0;
  logic [7:0]   regWdata = '0;
  logic [7:0]   regRdata;
  logic         irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [9:0] A_ROOT = 10'h1BB, A_M1 = 10'h1BC, A_M4 = 10'h1BF,
    A_SEL = 10'h1C0, A_PEND = 10'h1C1, A_CFG = 10'h1C2, A_RT = 10'h1C3;

  irq_tree_top u0 (.clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [7:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] v;
    rd(A_ROOT, v); chk("R2 root", v, 8'h00);
    rd(A_SEL, v);  chk("R2 sel", v, 8'h00);
    rd(A_PEND, v); chk("R2 pend", v, 8'h00);
    chk("R2 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic tWindow();
    logic [7:0] v;
    wr(A_SEL, 8'h03);
    wr(10'h1C4, 8'h07); wr(10'h1BA, 8'h09);
    rd(A_SEL, v);     chk("R1 sel kept", v, 8'h03);
    rd(10'h1C4, v);   chk("R1 unused read", v, 8'h00);
    rd(A_CFG, v);     chk("R1 cfg reads 0", v, 8'h00);
  endtask

  task automatic tRealTime();
    logic [7:0] v;
    wr(A_SEL, 8'h05);
    @(negedge clk); srcIn[43] = 1'b1;
    settle();
    rd(A_RT, v);   chk("R3 rt", v, 8'h08);
    rd(A_PEND, v); chk("R8 masked default", v, 8'h00);
  endtask

  task automatic tRiseEdge();
    logic [7:0] v;
    wr(A_SEL, 8'h02);
    wr(A_CFG, 8'h12);
    @(negedge clk); srcIn[17] = 1'b1; settle();
    rd(A_PEND, v); chk("R4 no we", v, 8'h00);
    @(negedge clk); srcIn[17] = 1'b0; settle();
    wr(A_CFG, 8'h92);
    @(negedge clk); srcIn[17] = 1'b1; settle();
    rd(A_PEND, v); chk("R5 rise", v, 8'h02);
    rd(A_M1, v);   chk("R9 master1", v, 8'h04);
    rd(A_ROOT, v); chk("R9 root", v, 8'h02);
    chk("R10 irq high", {7'b0, irqOut}, 8'h01);
    @(negedge clk); srcIn[17] = 1'b0; settle();
    rd(A_PEND, v); chk("R5 hold", v, 8'h02);
    wr(A_CFG, 8'h9A);
    rd(A_PEND, v); chk("R5 clear", v, 8'h00);
    chk("R10 irq low", {7'b0, irqOut}, 8'h00);
    @(negedge clk); srcIn[17] = 1'b1; settle();
    wr(A_CFG, 8'h92);
    rd(A_PEND, v); chk("R11 clear not stored", v, 8'h02);
    wr(A_CFG, 8'h9A);
    rd(A_PEND, v); chk("R11 cleared", v, 8'h00);
  endtask

  task automatic tBothEdges();
    logic [7:0] v;
    wr(A_SEL, 8'd25);
    wr(A_CFG, 8'h80);
    @(negedge clk); srcIn[200] = 1'b1; settle();
    rd(A_PEND, v); chk("R6 rise", v, 8'h01);
    rd(A_M4, v);   chk("R9 master4", v, 8'h02);
    rd(A_ROOT, v); chk("R9 root m3", v, 8'h10);
    wr(A_CFG, 8'h88);
    rd(A_PEND, v); chk("R6 clear", v, 8'h00);
    @(negedge clk); srcIn[200] = 1'b0; settle();
    rd(A_PEND, v); chk("R6 fall", v, 8'h01);
    wr(A_CFG, 8'h88);
  endtask

  task automatic tLevel();
    logic [7:0] v;
    wr(A_SEL, 8'd31);
    wr(A_CFG, 8'hF3); settle();
    rd(A_PEND, v); chk("R7 idle low", v, 8'h00);
    @(negedge clk); srcIn[255] = 1'b1; settle();
    rd(A_PEND, v); chk("R7 high", v, 8'h80);
    wr(A_CFG, 8'hFB);
    rd(A_PEND, v); chk("R7 reassert", v, 8'h80);
    @(negedge clk); srcIn[255] = 1'b0; settle();
    wr(A_CFG, 8'hFB);
    rd(A_PEND, v); chk("R7 cleared inactive", v, 8'h00);
    wr(A_CFG, 8'hF5); repeat (2) @(negedge clk);
    rd(A_PEND, v); chk("R7 active low", v, 8'h80);
    @(negedge clk); srcIn[255] = 1'b1; settle();
    wr(A_CFG, 8'hFD);
    rd(A_PEND, v); chk("R7 low cleared", v, 8'h00);
  endtask

  task automatic tMasked();
    logic [7:0] v;
    wr(A_SEL, 8'd12);
    wr(A_CFG, 8'hC6);
    @(negedge clk); srcIn[100] = 1'b1; settle();
    @(negedge clk); srcIn[100] = 1'b0; settle();
    rd(A_PEND, v); chk("R8 masked", v, 8'h00);
    rd(A_ROOT, v); chk("R8 root quiet", v, 8'h00);
    chk("R10 irq quiet", {7'b0, irqOut}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWindow();
    tRealTime();
    tRiseEdge();
    tBothEdges();
    tLevel();
    tMasked();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule